// File: doc/BRIEF.md
# Instruction address trigger unit

This block is one hardware breakpoint for a small in-order core. It holds a programmed instruction address and a small configuration word. It compares the address of the instruction that sits at the issue stage against the programmed value. On an exact hit it raises a one-cycle request in that same cycle, either a breakpoint exception or a debug-mode entry. The issue stage uses the request to hold back that instruction. The reported PC is the address of the held-back instruction, so a normal return resumes at it.

Software programs the unit through a plain CSR write/read port. The configuration word sits at CSR address 0x7A1 and the address register at 0x7A2. A debug-only lock bit lets an external debugger claim the trigger. While the lock is set, code running outside debug mode cannot change either register.

Top module: `instr_addr_trigger`

## Requirements
- R1: The configuration word at CSR 0x7A1 reads as follows. Bits [31:28] hold the constant 6. The lock bit is bit 27, the hit flag is bit 22, the action bit is bit 12, the machine enable is bit 6, the user enable is bit 3 and the execute enable is bit 2. All other bits read 0. After reset every stored field is 0. The address register at 0x7A2 reads 0 after reset. Any other CSR address reads 0.
- R2: `trig_fire_o` is high in the same cycle as a valid issue only when all of these hold: the execute enable is set, the enable for the current privilege is set, the core is not in debug mode, and the issue PC equals the address register.
- R3: Matching uses full-width equality. A PC that differs from the programmed address in any single bit does not fire.
- R4: The machine enable gates matches when `priv_m_i`=1. The user enable gates matches when `priv_m_i`=0.
- R5: On a fire, action bit 0 raises only `trig_exc_o` and action bit 1 raises only `trig_dbg_o`. Neither is raised without a fire.
- R6: During a fire, `trig_pc_o` equals the issue PC of the matching instruction.
- R7: The hit flag reads 1 from the cycle after a fire. A CSR write to 0x7A1 in the fire cycle does not clear it.
- R8: No fire occurs while `dbg_mode_i`=1.
- R9: While the lock bit is set, writes to 0x7A1 and 0x7A2 have no effect unless `dbg_mode_i`=1. Writes made in debug mode take effect.
- R10: The lock bit can become 1 only through a write made in debug mode. A machine-mode write of 1 leaves it at 0.
- R11: A write with `priv_m_i`=0 and `dbg_mode_i`=0 changes nothing.
- R12: A match in the same cycle as a configuration write is judged on the values held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 12 | CSR address for reads and writes |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| priv_m_i | input | 1 | 1 = machine mode, 0 = user mode |
| dbg_mode_i | input | 1 | Core is in debug mode |
| issue_valid_i | input | 1 | Instruction present at issue stage |
| issue_pc_i | input | XLEN | Address of issuing instruction |
| trig_fire_o | output | 1 | Trigger match pulse |
| trig_exc_o | output | 1 | Raise breakpoint exception |
| trig_dbg_o | output | 1 | Request debug-mode entry |
| trig_pc_o | output | XLEN | PC to save for the return |

## Verification
A CSR write to the configuration word and a match at the issue stage can fall in the same cycle. The bench provokes this by arming the trigger and then presenting the programmed PC in the same cycle as a write. That write clears the execute enable and the hit flag. The expected result is a fire in that cycle, because the match uses the old values. In the following cycle the read-back shows the execute enable cleared and the hit flag set, because the hardware set wins over the written 0.

// File: rtl/trig_pkg.sv
package trig_pkg;
  localparam logic [11:0] CSR_CFG   = 12'h7A1;
  localparam logic [11:0] CSR_TADDR = 12'h7A2;
  localparam logic [3:0]  TRIG_KIND = 4'd6;

  localparam int unsigned HIT_BIT = 22;
  localparam int unsigned ACT_BIT = 12;
  localparam int unsigned M_BIT   = 6;
  localparam int unsigned U_BIT   = 3;
  localparam int unsigned EXE_BIT = 2;

  typedef struct packed {
    logic dmode;
    logic hit;
    logic act;   // 0: breakpoint exception, 1: debug entry
    logic m_en;
    logic u_en;
    logic exe;
  } trig_cfg_t;
endpackage

// File: rtl/trig_csr.sv
module trig_csr
  import trig_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [11:0]     addr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic            priv_m_i,
  input  logic            dbg_mode_i,
  input  logic            hit_set_i,
  output trig_cfg_t       cfg_o,
  output logic [XLEN-1:0] taddr_o,
  output logic [XLEN-1:0] rdata_o
);
  localparam int unsigned KIND_LSB = XLEN - 4;
  localparam int unsigned LOCK_BIT = XLEN - 5;

  trig_cfg_t       cfg_q;
  logic [XLEN-1:0] taddr_q;
  logic            wr_ok;

  // lock: only debug mode may touch the registers
  assign wr_ok = we_i && (priv_m_i || dbg_mode_i) && (!cfg_q.dmode || dbg_mode_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q   <= '0;
      taddr_q <= '0;
    end else begin
      if (wr_ok && addr_i == CSR_CFG) begin
        cfg_q.dmode <= wdata_i[LOCK_BIT] & dbg_mode_i;
        cfg_q.hit   <= wdata_i[HIT_BIT];
        cfg_q.act   <= wdata_i[ACT_BIT];
        cfg_q.m_en  <= wdata_i[M_BIT];
        cfg_q.u_en  <= wdata_i[U_BIT];
        cfg_q.exe   <= wdata_i[EXE_BIT];
      end
      if (hit_set_i) cfg_q.hit <= 1'b1;
      if (wr_ok && addr_i == CSR_TADDR) taddr_q <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CSR_CFG) begin
      rdata_o[KIND_LSB +: 4] = TRIG_KIND;
      rdata_o[LOCK_BIT]      = cfg_q.dmode;
      rdata_o[HIT_BIT]       = cfg_q.hit;
      rdata_o[ACT_BIT]       = cfg_q.act;
      rdata_o[M_BIT]         = cfg_q.m_en;
      rdata_o[U_BIT]         = cfg_q.u_en;
      rdata_o[EXE_BIT]       = cfg_q.exe;
    end else if (addr_i == CSR_TADDR) begin
      rdata_o = taddr_q;
    end
  end

  assign cfg_o   = cfg_q;
  assign taddr_o = taddr_q;
endmodule

// File: rtl/trig_match.sv
module trig_match
  import trig_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  trig_cfg_t       cfg_i,
  input  logic [XLEN-1:0] taddr_i,
  input  logic            issue_valid_i,
  input  logic [XLEN-1:0] issue_pc_i,
  input  logic            priv_m_i,
  input  logic            dbg_mode_i,
  output logic            fire_o,
  output logic            exc_o,
  output logic            dbg_o,
  output logic [XLEN-1:0] pc_o
);
  logic priv_ok;
  logic addr_eq;

  assign priv_ok = priv_m_i ? cfg_i.m_en : cfg_i.u_en;
  assign addr_eq = (issue_pc_i == taddr_i);
  assign fire_o  = issue_valid_i && cfg_i.exe && priv_ok && addr_eq && !dbg_mode_i;
  assign exc_o   = fire_o && !cfg_i.act;
  assign dbg_o   = fire_o &&  cfg_i.act;
  // instruction is held back, so return resumes at it
  assign pc_o    = issue_pc_i;
endmodule

// File: rtl/instr_addr_trigger.sv
module instr_addr_trigger
  import trig_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  input  logic            priv_m_i,
  input  logic            dbg_mode_i,
  input  logic            issue_valid_i,
  input  logic [XLEN-1:0] issue_pc_i,
  output logic            trig_fire_o,
  output logic            trig_exc_o,
  output logic            trig_dbg_o,
  output logic [XLEN-1:0] trig_pc_o
);
  trig_cfg_t       cfg_q;
  logic [XLEN-1:0] taddr_q;

  trig_csr #(.XLEN(XLEN)) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (csr_we_i),
    .addr_i     (csr_addr_i),
    .wdata_i    (csr_wdata_i),
    .priv_m_i   (priv_m_i),
    .dbg_mode_i (dbg_mode_i),
    .hit_set_i  (trig_fire_o),
    .cfg_o      (cfg_q),
    .taddr_o    (taddr_q),
    .rdata_o    (csr_rdata_o)
  );

  trig_match #(.XLEN(XLEN)) u_match (
    .cfg_i         (cfg_q),
    .taddr_i       (taddr_q),
    .issue_valid_i (issue_valid_i),
    .issue_pc_i    (issue_pc_i),
    .priv_m_i      (priv_m_i),
    .dbg_mode_i    (dbg_mode_i),
    .fire_o        (trig_fire_o),
    .exc_o         (trig_exc_o),
    .dbg_o         (trig_dbg_o),
    .pc_o          (trig_pc_o)
  );
endmodule

// File: rtl/trig_checker.sv
module trig_checker #(
  parameter int unsigned XLEN = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            fire_i,
  input logic            exc_i,
  input logic            dbg_i,
  input logic            dbg_mode_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] pc_o_i,
  input logic            dmode_i,
  input logic            hit_i,
  input logic [XLEN-1:0] taddr_i
);
  assert_one_action_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((exc_i || dbg_i) == fire_i) && !(exc_i && dbg_i));

  assert_no_fire_dbg_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dbg_mode_i |-> !fire_i);

  assert_pc_saved_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> pc_o_i == pc_i);

  assert_hit_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> hit_i);

  assert_lock_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dmode_i && !dbg_mode_i) |=> $stable(taddr_i));

  assert_lock_from_dbg_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dmode_i) |-> $past(dbg_mode_i));
endmodule

bind instr_addr_trigger trig_checker #(.XLEN(XLEN)) u_trig_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fire_i     (trig_fire_o),
  .exc_i      (trig_exc_o),
  .dbg_i      (trig_dbg_o),
  .dbg_mode_i (dbg_mode_i),
  .pc_i       (issue_pc_i),
  .pc_o_i     (trig_pc_o),
  .dmode_i    (cfg_q.dmode),
  .hit_i      (cfg_q.hit),
  .taddr_i    (taddr_q)
);

// File: tb/instr_addr_trigger_bench.sv
module instr_addr_trigger_bench;
  localparam int XLEN = 32;
  localparam logic [11:0] A_CFG = 12'h7A1;
  localparam logic [11:0] A_ADR = 12'h7A2;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            we = 0;
  logic [11:0]     caddr = '0;
  logic [XLEN-1:0] wdata = '0;
  logic [XLEN-1:0] rdata;
  logic            priv_m = 1;
  logic            dbg = 0;
  logic            iv = 0;
  logic [XLEN-1:0] ipc = '0;
  logic            fire, exc, dreq;
  logic [XLEN-1:0] tpc;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  instr_addr_trigger #(.XLEN(XLEN)) u_instr_addr_trigger (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(caddr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .priv_m_i(priv_m),
    .dbg_mode_i(dbg), .issue_valid_i(iv), .issue_pc_i(ipc),
    .trig_fire_o(fire), .trig_exc_o(exc), .trig_dbg_o(dreq), .trig_pc_o(tpc)
  );

  function automatic logic [31:0] cfgv(logic dm, logic h, logic a, logic m, logic u, logic x);
    return (32'd6 << 28) | (32'(dm) << 27) | (32'(h) << 22) | (32'(a) << 12)
         | (32'(m) << 6) | (32'(u) << 3) | (32'(x) << 2);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); we = 1; caddr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); caddr = a; #1; d = rdata;
  endtask

  // present one instruction; checks sampled 1 ns after negedge
  task automatic issue(logic [31:0] pc, logic ef, logic ee, logic ed, string req);
    @(negedge clk); iv = 1; ipc = pc; #1;
    check(req, {31'd0, fire}, {31'd0, ef});
    check("R5", {30'd0, exc, dreq}, {30'd0, ee, ed});
    if (ef) check("R6", tpc, pc);
    @(negedge clk); iv = 0;
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    rd(A_CFG, d); check("R1 cfg reset", d, cfgv(0,0,0,0,0,0));
    rd(A_ADR, d); check("R1 addr reset", d, 0);
    rd(12'h7A3, d); check("R1 other addr", d, 0);
    issue(32'h0, 0, 0, 0, "R2 disarmed after reset");

    // R2 R4 R5: sweep enables, privilege, action over nearby PCs
    wr(A_ADR, 32'h100);
    for (int c = 0; c < 32; c++) begin
      logic x, m, u, a, p, hitexp;
      {x, m, u, a, p} = 5'(c);
      hitexp = 0;
      priv_m = 1; dbg = 0;
      wr(A_CFG, cfgv(0,0,a,m,u,x));
      rd(A_CFG, d); check("R1 cfg readback", d, cfgv(0,0,a,m,u,x));
      priv_m = p;
      for (int k = -4; k <= 4; k++) begin
        logic [31:0] pc;
        logic ef;
        pc = 32'h100 + 32'(k*4);
        ef = x && (p ? m : u) && (pc == 32'h100);
        if (ef) hitexp = 1;
        issue(pc, ef, ef && !a, ef && a, "R4 R2 sweep");
      end
      rd(A_CFG, d); check("R7 hit after sweep", {31'd0, d[22]}, {31'd0, hitexp});
    end

    // R3 walking-bit exact equality
    priv_m = 1;
    wr(A_CFG, cfgv(0,0,0,1,0,1));
    for (int i = 0; i < 32; i++) begin
      logic [31:0] t;
      t = 32'd1 << i;
      wr(A_ADR, t);
      issue(t, 1, 1, 0, "R3 exact hit");
      issue(t ^ (32'd1 << ((i + 7) % 32)), 0, 0, 0, "R3 one-bit miss");
    end

    // R11 user-mode write ignored
    wr(A_ADR, 32'h200);
    priv_m = 0;
    wr(A_ADR, 32'h300);
    wr(A_CFG, 32'h0);
    priv_m = 1;
    rd(A_ADR, d); check("R11 addr kept", d, 32'h200);
    rd(A_CFG, d); check("R11 cfg kept", {28'd0, d[27:24]} | {31'd0, d[2]}, 32'd1);

    // R10 machine write cannot set lock
    wr(A_CFG, cfgv(1,0,1,1,0,1));
    rd(A_CFG, d); check("R10 lock stays 0", d, cfgv(0,0,1,1,0,1));

    // R9 lock from debug, machine writes dropped
    dbg = 1;
    wr(A_CFG, cfgv(1,0,1,1,0,1));
    wr(A_ADR, 32'h400);
    rd(A_CFG, d); check("R10 lock set in debug", d, cfgv(1,0,1,1,0,1));
    issue(32'h400, 0, 0, 0, "R8 no fire in debug");
    dbg = 0;
    wr(A_CFG, cfgv(0,0,0,0,0,0));
    wr(A_ADR, 32'h500);
    rd(A_CFG, d); check("R9 cfg locked", d, cfgv(1,0,1,1,0,1));
    rd(A_ADR, d); check("R9 addr locked", d, 32'h400);
    issue(32'h400, 1, 0, 1, "R9 locked trigger fires debug action");
    dbg = 1;
    wr(A_ADR, 32'h600);
    rd(A_ADR, d); check("R9 debug write accepted", d, 32'h600);
    wr(A_CFG, cfgv(0,0,0,1,0,1));
    dbg = 0;
    rd(A_CFG, d); check("R9 lock cleared in debug", d, cfgv(0,0,0,1,0,1));

    // R12 R7 write and match in the same cycle
    @(negedge clk); iv = 1; ipc = 32'h600; we = 1; caddr = A_CFG; wdata = cfgv(0,0,0,1,0,0); #1;
    check("R12 fire on old cfg", {31'd0, fire}, 32'd1);
    check("R12 exc on old cfg", {31'd0, exc}, 32'd1);
    @(negedge clk); iv = 0; we = 0;
    rd(A_CFG, d); check("R7 hit wins over write", d, cfgv(0,1,0,1,0,0));
    issue(32'h600, 0, 0, 0, "R12 new cfg disarms");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule